// File: doc/BRIEF.md
# Receive Bit-Timing Error Checker

This block watches the synchronized, sampled level of a single-wire, open-drain bus while a receiver is active and judges the timing of every data bit. A bit begins with a falling edge. The checker measures, in units of a 0.1 ms timing strobe, how long the line stays low and when the next falling edge arrives. It compares both against nominal windows. Two nominal low times are legal: a short one for a logic 1 and a long one for a logic 0. The nominal bit period is fixed, and an input widens all windows from a standard to an extended tolerance.

Three error classes come out as single-cycle pulses. A misplaced rising edge is reported either at the offending edge or when the low phase outlasts its latest legal instant. A short bit period is reported at the early falling edge. A long bit period is reported when the latest legal falling-edge instant passes. For each error the block also pulses a stop-reception request and an error-bit request, following per-class rules taken from configuration and broadcast inputs. After any error the checker goes back to waiting for a fresh falling edge. Turning the bits into bytes and shaping the error-bit waveform are left to neighbouring blocks.

Top module: `bit_timing_checker`

## Requirements
- R1: After reset all five outputs are 0 and stay 0 while the line rests high.
- R2: With `tick_i` high every cycle, a rising edge at elapsed count e is accepted when |e-6| or |e-15| is at most the tolerance T. T is 2, or 3 when `ext_tol_i`=1. Any other e gives a one-cycle `rise_err_o` pulse in the cycle after the edge is sampled.
- R3: If the line is still low when the elapsed count reaches 15+T+1, `rise_err_o` pulses in the following cycle, with no rising edge needed.
- R4: After an accepted rising edge, a falling edge at elapsed count below 24-T gives a one-cycle `short_err_o` pulse.
- R5: After an accepted rising edge, reaching elapsed count 24+T+1 without a legal falling edge gives a one-cycle `long_err_o` pulse.
- R6: A falling edge at elapsed count 24-T to 24+T starts the next bit, and the elapsed count restarts from that edge.
- R7: `ext_tol_i`=1 widens every window by one tick on each side compared with `ext_tol_i`=0.
- R8: `stop_rx_o` pulses with every long-period error. It pulses with a rising-edge error only when `stop_on_rise_i`=1, and never with a short-period error.
- R9: `err_bit_req_o` pulses with every short-period error. It pulses with a rising-edge error only when `gen_on_rise_i`=1, and with a long-period error when `gen_on_long_i`=1 or `bcast_i`=1.
- R10: Elapsed time advances only in cycles with `tick_i`=1.
- R11: While `rx_active_i`=0 no error pulses, and the checker returns to waiting for a falling edge.
- R12: At most one error class pulses at a time, and after an error no further error is reported until a new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 0.1 ms timing strobe |
| line_i | input | 1 | Synchronized bus level, 1 = released high |
| rx_active_i | input | 1 | Receiver active; 0 forces the idle state |
| ext_tol_i | input | 1 | 1 selects the extended tolerance |
| stop_on_rise_i | input | 1 | A rising-edge error also requests stop |
| gen_on_rise_i | input | 1 | A rising-edge error also requests an error bit |
| gen_on_long_i | input | 1 | A long-period error also requests an error bit |
| bcast_i | input | 1 | The current message is a broadcast |
| rise_err_o | output | 1 | Misplaced rising edge pulse |
| short_err_o | output | 1 | Short bit period pulse |
| long_err_o | output | 1 | Long bit period pulse |
| stop_rx_o | output | 1 | Stop reception request pulse |
| err_bit_req_o | output | 1 | Error-bit request pulse |

## Verification
The bench builds the block with its default timing parameters: period 24, rising points 6 and 15, tolerances 2 and 3. Because `tick_i` is held high, every tick equals one clock, and a full sweep of the rising-edge position from 1 to 20 and of the bit period from 8 to 30 takes only a few thousand cycles. Each sweep runs in both tolerance settings and is compared with window arithmetic done in the bench. A half-rate strobe then shows that time is counted in ticks and not in cycles. All sixteen configuration and broadcast combinations are applied to each error class.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } btc_state_e;

  typedef struct packed {
    logic rise;
    logic short_p;
    logic long_p;
  } btc_err_t;
endpackage

// File: rtl/btc_window.sv
module btc_window #(
  parameter int PERIOD    = 24,
  parameter int ONE_RISE  = 6,
  parameter int ZERO_RISE = 15,
  parameter int TOL_STD   = 2,
  parameter int TOL_EXT   = 3,
  parameter int CNT_W     = 6
) (
  input  logic [CNT_W-1:0] elapsed_i,
  input  logic             ext_tol_i,
  output logic             rise_ok_o,
  output logic             rise_over_o,
  output logic             per_short_o,
  output logic             per_over_o
);
  localparam int N_PTS = 2;
  localparam int PTS [N_PTS] = '{ONE_RISE, ZERO_RISE};
  localparam int LATE_RISE = (ONE_RISE > ZERO_RISE) ? ONE_RISE : ZERO_RISE;

  int tol;
  int e_i;
  logic [N_PTS-1:0] in_pt;

  always_comb begin
    tol = ext_tol_i ? TOL_EXT : TOL_STD;
    e_i = int'(elapsed_i);
  end

  // one window comparator per nominal rising point
  for (genvar g = 0; g < N_PTS; g++) begin : g_pt
    assign in_pt[g] = (e_i + tol >= PTS[g]) && (e_i <= PTS[g] + tol);
  end

  always_comb begin
    rise_ok_o   = |in_pt;
    rise_over_o = e_i > LATE_RISE + tol;
    per_short_o = e_i < PERIOD - tol;
    per_over_o  = e_i > PERIOD + tol;
  end
endmodule

// File: rtl/btc_fsm.sv
module btc_fsm
  import btc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             rx_active_i,
  input  logic             rise_ok_i,
  input  logic             rise_over_i,
  input  logic             per_short_i,
  input  logic             per_over_i,
  output logic [CNT_W-1:0] elapsed_o,
  output btc_err_t         hit_o
);
  btc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, load_zero, counting;
  logic             line_q;
  logic             fall, rise;

  always_comb begin
    fall      = line_q & ~line_i;
    rise      = ~line_q & line_i;
    counting  = (st_q == ST_LOW) || (st_q == ST_HIGH);
    elapsed_o = cnt_q + CNT_W'(tick_i);
  end

  // next-state process
  always_comb begin
    st_d      = st_q;
    load_zero = 1'b0;
    hit_o     = '0;
    if (!rx_active_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (fall) begin
            st_d      = ST_LOW;
            load_zero = 1'b1;
          end
        end
        ST_LOW: begin
          if (rise_over_i) begin
            hit_o.rise = 1'b1;
            st_d       = ST_IDLE;
          end else if (rise) begin
            if (rise_ok_i) begin
              st_d = ST_HIGH;
            end else begin
              hit_o.rise = 1'b1;
              st_d       = ST_IDLE;
            end
          end
        end
        ST_HIGH: begin
          if (per_over_i) begin
            hit_o.long_p = 1'b1;
            st_d         = ST_IDLE;
          end else if (fall) begin
            if (per_short_i) begin
              hit_o.short_p = 1'b1;
              st_d          = ST_IDLE;
            end else begin
              st_d      = ST_LOW;
              load_zero = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    cnt_en = load_zero | (tick_i & counting & rx_active_i);
    cnt_d  = load_zero ? '0 : elapsed_o;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      line_q <= line_i;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // R10: with no tick and the line held low, the measured time stands still
  p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW && !tick_i && !line_i && rx_active_i) |=> (cnt_q == $past(cnt_q)));

  // R12: an error always returns the checker to idle
  p_error_to_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_o) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/btc_policy.sv
module btc_policy
  import btc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  btc_err_t hit_i,
  input  logic     stop_on_rise_i,
  input  logic     gen_on_rise_i,
  input  logic     gen_on_long_i,
  input  logic     bcast_i,
  output btc_err_t err_o,
  output logic     stop_o,
  output logic     errbit_o
);
  logic stop_d, errbit_d;

  always_comb begin
    stop_d   = (hit_i.rise & stop_on_rise_i) | hit_i.long_p;
    errbit_d = (hit_i.rise & gen_on_rise_i) | hit_i.short_p |
               (hit_i.long_p & (gen_on_long_i | bcast_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o    <= '0;
      stop_o   <= 1'b0;
      errbit_o <= 1'b0;
    end else begin
      err_o    <= hit_i;
      stop_o   <= stop_d;
      errbit_o <= errbit_d;
    end
  end

  // R12: error classes are exclusive and single-cycle
  p_one_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_o.rise, err_o.short_p, err_o.long_p}));
  p_err_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_o) |=> !(|err_o));
  // R8: long always stops, short never stops
  p_long_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o.long_p |-> stop_o);
  p_short_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o.short_p |-> !stop_o);
  // R9: broadcast forces the error bit on a long period
  p_bcast_long_errbit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i.long_p && bcast_i) |=> errbit_o);
endmodule

// File: rtl/bit_timing_checker.sv
module bit_timing_checker
  import btc_pkg::*;
#(
  parameter int PERIOD    = 24,
  parameter int ONE_RISE  = 6,
  parameter int ZERO_RISE = 15,
  parameter int TOL_STD   = 2,
  parameter int TOL_EXT   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  input  logic rx_active_i,
  input  logic ext_tol_i,
  input  logic stop_on_rise_i,
  input  logic gen_on_rise_i,
  input  logic gen_on_long_i,
  input  logic bcast_i,
  output logic rise_err_o,
  output logic short_err_o,
  output logic long_err_o,
  output logic stop_rx_o,
  output logic err_bit_req_o
);
  localparam int CNT_W = $clog2(PERIOD + TOL_EXT + 2) + 1;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [CNT_W-1:0] elapsed;
  logic             rise_ok, rise_over, per_short, per_over;
  btc_err_t         hit, err;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  btc_window #(
    .PERIOD(PERIOD), .ONE_RISE(ONE_RISE), .ZERO_RISE(ZERO_RISE),
    .TOL_STD(TOL_STD), .TOL_EXT(TOL_EXT), .CNT_W(CNT_W)
  ) u_window (
    .elapsed_i   (elapsed),
    .ext_tol_i   (ext_tol_i),
    .rise_ok_o   (rise_ok),
    .rise_over_o (rise_over),
    .per_short_o (per_short),
    .per_over_o  (per_over)
  );

  btc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick_i      (tick_i),
    .line_i      (line_i),
    .rx_active_i (rx_active_i),
    .rise_ok_i   (rise_ok),
    .rise_over_i (rise_over),
    .per_short_i (per_short),
    .per_over_i  (per_over),
    .elapsed_o   (elapsed),
    .hit_o       (hit)
  );

  btc_policy u_policy (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .hit_i          (hit),
    .stop_on_rise_i (stop_on_rise_i),
    .gen_on_rise_i  (gen_on_rise_i),
    .gen_on_long_i  (gen_on_long_i),
    .bcast_i        (bcast_i),
    .err_o          (err),
    .stop_o         (stop_rx_o),
    .errbit_o       (err_bit_req_o)
  );

  assign rise_err_o  = err.rise;
  assign short_err_o = err.short_p;
  assign long_err_o  = err.long_p;

  // R11: an inactive receiver raises no error in the next cycle
  p_inactive_quiet_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rx_active_i |=> !(rise_err_o || short_err_o || long_err_o));
endmodule

// File: tb/bit_timing_checker_tb.sv
module bit_timing_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic tick_half = 1'b0;
  logic line = 1'b1;
  logic rx_active = 1'b0;
  logic ext_tol = 1'b0;
  logic stop_on_rise = 1'b0;
  logic gen_on_rise = 1'b0;
  logic gen_on_long = 1'b0;
  logic bcast = 1'b0;
  logic rise_err, short_err, long_err, stop_rx, err_bit_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int n_rise = 0, n_short = 0, n_long = 0, n_stop = 0, n_gen = 0;

  always #4 clk = ~clk;

  bit_timing_checker u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line),
    .rx_active_i(rx_active), .ext_tol_i(ext_tol),
    .stop_on_rise_i(stop_on_rise), .gen_on_rise_i(gen_on_rise),
    .gen_on_long_i(gen_on_long), .bcast_i(bcast),
    .rise_err_o(rise_err), .short_err_o(short_err), .long_err_o(long_err),
    .stop_rx_o(stop_rx), .err_bit_req_o(err_bit_req)
  );

  always @(negedge clk) begin
    tick <= tick_half ? ~tick : 1'b1;
    n_rise  += int'(rise_err);
    n_short += int'(short_err);
    n_long  += int'(long_err);
    n_stop  += int'(stop_rx);
    n_gen   += int'(err_bit_req);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    rx_active = 1'b0;
    line = 1'b1;
    repeat (3) @(negedge clk);
    rx_active = 1'b1;
    @(negedge clk);
    #1;
  endtask

  // one bit: low for lo cycles, falling edge after per cycles
  task automatic run_bit(input int lo, input int per,
                         output int dr, output int ds, output int dl,
                         output int dst, output int dg);
    int b_r, b_s, b_l, b_st, b_g;
    go_idle();
    b_r = n_rise; b_s = n_short; b_l = n_long; b_st = n_stop; b_g = n_gen;
    line = 1'b0;
    repeat (lo) @(negedge clk);
    line = 1'b1;
    repeat (per - lo) @(negedge clk);
    line = 1'b0;
    repeat (3) @(negedge clk);
    rx_active = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    dr = n_rise - b_r; ds = n_short - b_s; dl = n_long - b_l;
    dst = n_stop - b_st; dg = n_gen - b_g;
  endtask

  function automatic bit rise_bad(input int lo, input int t);
    return !(((lo >= 6 - t) && (lo <= 6 + t)) || ((lo >= 15 - t) && (lo <= 15 + t)));
  endfunction

  initial begin
    int dr, ds, dl, dst, dg;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rx_active = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state and quiet idle line
    repeat (20) begin
      @(negedge clk);
      check("R1 outputs idle", int'({rise_err, short_err, long_err, stop_rx, err_bit_req}), 0);
    end

    // R2 exact timing: rise at 10 ticks with standard tolerance
    go_idle();
    line = 1'b0;
    repeat (10) @(negedge clk);
    line = 1'b1;
    @(negedge clk);
    check("R2 misplaced rise pulse", int'(rise_err), 1);
    @(negedge clk);
    check("R2 pulse one cycle", int'(rise_err), 0);

    // R3 exact timing: line held low, timeout after 17 ticks
    go_idle();
    line = 1'b0;
    repeat (18) @(negedge clk);
    check("R3 no error at max", int'(rise_err), 0);
    @(negedge clk);
    check("R3 timeout pulse", int'(rise_err), 1);
    @(negedge clk);
    check("R3 pulse one cycle", int'(rise_err), 0);

    // R2/R3/R7: rising-edge sweep in both tolerances
    for (int x = 0; x < 2; x++) begin
      ext_tol = x[0];
      for (int lo = 1; lo <= 20; lo++) begin
        run_bit(lo, 24, dr, ds, dl, dst, dg);
        check($sformatf("R2 R7 rise sweep lo=%0d ext=%0d", lo, x), dr,
              int'(rise_bad(lo, 2 + x)));
        check($sformatf("R6 rise sweep others lo=%0d ext=%0d", lo, x), ds + dl, 0);
      end
    end

    // R4/R5/R6/R7: period sweep in both tolerances
    for (int x = 0; x < 2; x++) begin
      ext_tol = x[0];
      for (int per = 8; per <= 30; per++) begin
        run_bit(6, per, dr, ds, dl, dst, dg);
        check($sformatf("R4 R7 short sweep per=%0d ext=%0d", per, x), ds,
              int'(per < 24 - (2 + x)));
        check($sformatf("R5 R7 long sweep per=%0d ext=%0d", per, x), dl,
              int'(per > 24 + (2 + x)));
        check($sformatf("R6 period sweep rise per=%0d", per), dr, 0);
      end
    end
    ext_tol = 1'b0;

    // R8/R9: policy for all configuration combinations
    for (int c = 0; c < 16; c++) begin
      stop_on_rise = c[0]; gen_on_rise = c[1]; gen_on_long = c[2]; bcast = c[3];
      run_bit(10, 24, dr, ds, dl, dst, dg);
      check($sformatf("R8 rise stop c=%0d", c), dst, c[0] ? 1 : 0);
      check($sformatf("R9 rise errbit c=%0d", c), dg, c[1] ? 1 : 0);
      run_bit(6, 12, dr, ds, dl, dst, dg);
      check($sformatf("R8 short stop c=%0d", c), dst, 0);
      check($sformatf("R9 short errbit c=%0d", c), dg, 1);
      run_bit(6, 30, dr, ds, dl, dst, dg);
      check($sformatf("R8 long stop c=%0d", c), dst, 1);
      check($sformatf("R9 long errbit c=%0d", c), dg, (c[2] || c[3]) ? 1 : 0);
    end
    stop_on_rise = 1'b0; gen_on_rise = 1'b0; gen_on_long = 1'b0; bcast = 1'b0;

    // R6: chained bits, measurement restarts at each legal falling edge
    go_idle();
    begin
      int b_r, b_s, b_l;
      b_r = n_rise; b_s = n_short; b_l = n_long;
      line = 1'b0; repeat (6) @(negedge clk); line = 1'b1; repeat (18) @(negedge clk);
      line = 1'b0; repeat (15) @(negedge clk); line = 1'b1; repeat (9) @(negedge clk);
      line = 1'b0; repeat (6) @(negedge clk); line = 1'b1; repeat (16) @(negedge clk);
      line = 1'b0; repeat (6) @(negedge clk); line = 1'b1; repeat (4) @(negedge clk);
      line = 1'b0; repeat (3) @(negedge clk);
      #1;
      check("R6 chain no rise err", n_rise - b_r, 0);
      check("R6 chain final short", n_short - b_s, 1);
      check("R6 chain no long", n_long - b_l, 0);
    end

    // R10: half-rate tick doubles the cycle lengths
    tick_half = 1'b1;
    run_bit(12, 48, dr, ds, dl, dst, dg);
    check("R10 half tick legal bit", dr + ds + dl, 0);
    run_bit(12, 20, dr, ds, dl, dst, dg);
    check("R10 half tick short", ds, 1);
    tick_half = 1'b0;
    @(negedge clk);

    // R11: receiver inactive, hostile waveform gives no error
    rx_active = 1'b0;
    line = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    begin
      int b_a;
      b_a = n_rise + n_short + n_long;
      line = 1'b0; repeat (3) @(negedge clk);
      line = 1'b1; repeat (3) @(negedge clk);
      line = 1'b0; repeat (50) @(negedge clk);
      line = 1'b1; repeat (50) @(negedge clk);
      #1;
      check("R11 inactive quiet", n_rise + n_short + n_long - b_a, 0);
    end

    // R12: one error then silence until a new falling edge
    go_idle();
    begin
      int b_r, b_a;
      b_r = n_rise; b_a = n_rise + n_short + n_long;
      line = 1'b0; repeat (50) @(negedge clk);
      line = 1'b1; repeat (50) @(negedge clk);
      #1;
      check("R12 single rise err", n_rise - b_r, 1);
      check("R12 nothing else", n_rise + n_short + n_long - b_a, 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule